// File: doc/BRIEF.md
# Link Training Supervisor with Stall Recovery

This block watches a serial link while it trains. A `start` pulse first writes a link capability word back with its speed field forced to the lowest generation. Training is then enabled. The block polls two status words from the link core at a fixed interval. It reports `link_up` once the link reports up and is no longer training. If the link stays down, each poll also reads a receiver-valid flag through a request/acknowledge PHY register port.

One combination marks a speed change that has stalled: the training state sits at the receiver-lock recovery code while the receiver is not valid. In that case the block pulses two receiver override bits in a PHY override register. It sets them by read-modify-write, holds them for a timed interval, and clears them by a second read-modify-write. If the link is still not up after a fixed number of polls, the block emits a one-cycle `fail` pulse and drops training enable.

All intervals count ticks from a shared prescaler, so simulation can shorten them through parameters. After `link_up` or `fail`, the block stays in a terminal state until the next `start`.

Top module: `lt_supervisor`

## Requirements
- R1: After reset, `link_up`, `fail`, `train_en`, `cap_we` and `phy_req` are all 0.
- R2: A `start` pulse in the idle or a terminal state produces `cap_we` high for exactly one cycle, with `cap_wdata` equal to `cap_rdata` except bits [3:0], which are 1. `train_en` rises in the following cycle.
- R3: The link counts as up when `link_stat` bit 4 is 1 and bit 29 is 0. `link_up` then rises and stays high until the next `start`, and no PHY access is made while it is high.
- R4: Each poll that does not find the link up reads PHY address 0x100D. `phy_req` stays high with address, direction and write data stable until `phy_ack`.
- R5: A stall is declared only when bit 0 of the 0x100D read data is 0 and bits [5:0] of `train_state` equal 0x0D; bits above bit 5 are ignored. Without a stall, no override register access takes place.
- R6: Recovery reads PHY address 0x1005 and writes back that value with bits 5 and 3 set. Later it reads 0x1005 again and writes the value with bits 5 and 3 cleared. All other bits are kept.
- R7: The set write and the clear write are at least HOLD_TICKS×TICK_DIV cycles apart, and at most 20 cycles more than that.
- R8: Consecutive status reads are at least POLL_TICKS×TICK_DIV cycles apart.
- R9: After MAX_POLLS polls that do not find the link up, `fail` is high for one cycle and `train_en` drops to 0. The block then makes no PHY access until the next `start`, which begins a new run.
- R10: When link-up and the stall condition hold in the same poll, link-up wins: `link_up` rises and no PHY access is made.
- R11: The link state is not re-examined after the last poll's wait interval. A link that comes up during that interval still ends in `fail`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a supervision run |
| link_stat | input | 32 | Link status word (bit 4 up, bit 29 training) |
| train_state | input | 32 | Training-state word, code in bits [5:0] |
| cap_rdata | input | 32 | Current link capability word |
| cap_we | output | 1 | Capability write strobe |
| cap_wdata | output | 32 | Capability word with speed field forced |
| train_en | output | 1 | Training state machine enable |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | PHY access is a write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY access acknowledge (one cycle) |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |
| link_up | output | 1 | Link established (level) |
| fail | output | 1 | Polling budget exhausted (pulse) |

## Verification
Two decisions can fall in the same poll: link-up detection and stall detection. The bench raises the link-up bits while the training code is 0x0D and the receiver flag reads invalid, and passes only if `link_up` rises one cycle after the poll and the PHY port stays silent. The budget timeout can also meet a link that comes up late. The bench raises link-up just after the last status read, inside the final wait, and expects `fail` with `link_up` still low.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CAP,
        S_POLL,
        S_RX_RD,
        S_OV_RD1,
        S_OV_WR1,
        S_HOLD,
        S_OV_RD2,
        S_OV_WR2,
        S_WAIT,
        S_UP,
        S_FAIL
    } lt_state_e;

endpackage

// File: rtl/lt_tick.sv
module lt_tick #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lt_interval.sv
module lt_interval #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         tick,
    output logic         done
);
    logic [W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)                    rem_d = val;
        else if (tick && rem_q != 0) rem_d = rem_q - W'(1);
    end

    assign done = (rem_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end
endmodule

// File: rtl/lt_status_decode.sv
module lt_status_decode #(
    parameter int UP_BIT     = 4,
    parameter int TRAIN_BIT  = 29,
    parameter int STATE_W    = 6,
    parameter int STUCK_CODE = 13
) (
    input  logic [31:0] link_stat,
    input  logic [31:0] train_state,
    input  logic        rx_valid,
    output logic        link_ok,
    output logic        stuck
);
    logic unused_bits;

    assign link_ok     = link_stat[UP_BIT] & ~link_stat[TRAIN_BIT];
    assign stuck       = ~rx_valid &
                         (train_state[STATE_W-1:0] == STATE_W'(STUCK_CODE));
    assign unused_bits = ^{link_stat, train_state[31:STATE_W]};
endmodule

// File: rtl/lt_supervisor.sv
module lt_supervisor
    import lt_pkg::*;
#(
    parameter int          TICK_DIV   = 125,
    parameter int          POLL_TICKS = 10,
    parameter int          HOLD_TICKS = 3000,
    parameter int          MAX_POLLS  = 4000,
    parameter int          UP_BIT     = 4,
    parameter int          TRAIN_BIT  = 29,
    parameter int          STATE_W    = 6,
    parameter int          STUCK_CODE = 13,
    parameter logic [15:0] RX_ADDR    = 16'h100D,
    parameter logic [15:0] OVR_ADDR   = 16'h1005,
    parameter logic [15:0] OVR_MASK   = 16'h0028,
    parameter logic [3:0]  SPEED_CAP  = 4'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] link_stat,
    input  logic [31:0] train_state,
    input  logic [31:0] cap_rdata,
    output logic        cap_we,
    output logic [31:0] cap_wdata,
    output logic        train_en,
    output logic        phy_req,
    output logic        phy_we,
    output logic [15:0] phy_addr,
    output logic [15:0] phy_wdata,
    input  logic        phy_ack,
    input  logic [15:0] phy_rdata,
    output logic        link_up,
    output logic        fail
);
    localparam int IVL_MAX = (HOLD_TICKS > POLL_TICKS) ? HOLD_TICKS : POLL_TICKS;
    localparam int IVL_W   = $clog2(IVL_MAX + 1);
    localparam int CNT_W   = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        lt_state_e        st;
        logic [CNT_W-1:0] polls;
        logic [15:0]      ovr;
        logic             link_up;
        logic             fail;
        logic             cap_we;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             ivl_load;
    logic [IVL_W-1:0] ivl_val;
    logic             tick, ivl_done, link_ok, stuck;

    lt_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ivl_load),
        .tick  (tick)
    );

    lt_interval #(.W(IVL_W)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ivl_load),
        .val   (ivl_val),
        .tick  (tick),
        .done  (ivl_done)
    );

    lt_status_decode #(
        .UP_BIT     (UP_BIT),
        .TRAIN_BIT  (TRAIN_BIT),
        .STATE_W    (STATE_W),
        .STUCK_CODE (STUCK_CODE)
    ) u_dec (
        .link_stat   (link_stat),
        .train_state (train_state),
        .rx_valid    (phy_rdata[0]),
        .link_ok     (link_ok),
        .stuck       (stuck)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.fail   = 1'b0;
        ctl_d.cap_we = 1'b0;
        ivl_load     = 1'b0;
        ivl_val      = '0;
        case (ctl_q.st)
            S_IDLE, S_UP, S_FAIL: begin
                if (start) begin
                    ctl_d.st      = S_CAP;
                    ctl_d.cap_we  = 1'b1;
                    ctl_d.link_up = 1'b0;
                    ctl_d.polls   = '0;
                end
            end
            S_CAP: ctl_d.st = S_POLL;
            S_POLL: begin
                if (link_ok) begin
                    ctl_d.st      = S_UP;
                    ctl_d.link_up = 1'b1;
                end else begin
                    ctl_d.st = S_RX_RD;
                end
            end
            S_RX_RD: begin
                if (phy_ack) begin
                    if (stuck) begin
                        ctl_d.st = S_OV_RD1;
                    end else begin
                        ctl_d.st = S_WAIT;
                        ivl_load = 1'b1;
                        ivl_val  = IVL_W'(POLL_TICKS);
                    end
                end
            end
            S_OV_RD1: begin
                if (phy_ack) begin
                    ctl_d.ovr = phy_rdata | OVR_MASK;
                    ctl_d.st  = S_OV_WR1;
                end
            end
            S_OV_WR1: begin
                if (phy_ack) begin
                    ctl_d.st = S_HOLD;
                    ivl_load = 1'b1;
                    ivl_val  = IVL_W'(HOLD_TICKS);
                end
            end
            S_HOLD: if (ivl_done) ctl_d.st = S_OV_RD2;
            S_OV_RD2: begin
                if (phy_ack) begin
                    ctl_d.ovr = phy_rdata & ~OVR_MASK;
                    ctl_d.st  = S_OV_WR2;
                end
            end
            S_OV_WR2: begin
                if (phy_ack) begin
                    ctl_d.st = S_WAIT;
                    ivl_load = 1'b1;
                    ivl_val  = IVL_W'(POLL_TICKS);
                end
            end
            S_WAIT: begin
                if (ivl_done) begin
                    if (ctl_q.polls == CNT_W'(MAX_POLLS - 1)) begin
                        ctl_d.st   = S_FAIL;
                        ctl_d.fail = 1'b1;
                    end else begin
                        ctl_d.polls = ctl_q.polls + CNT_W'(1);
                        ctl_d.st    = S_POLL;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, polls: '0, ovr: '0,
                       link_up: 1'b0, fail: 1'b0, cap_we: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cap_we    = ctl_q.cap_we;
    assign cap_wdata = {cap_rdata[31:4], SPEED_CAP};
    assign train_en  = !(ctl_q.st inside {S_IDLE, S_CAP, S_FAIL});
    assign phy_req   = ctl_q.st inside {S_RX_RD, S_OV_RD1, S_OV_WR1, S_OV_RD2, S_OV_WR2};
    assign phy_we    = ctl_q.st inside {S_OV_WR1, S_OV_WR2};
    assign phy_addr  = !phy_req ? 16'h0 : ((ctl_q.st == S_RX_RD) ? RX_ADDR : OVR_ADDR);
    assign phy_wdata = phy_we ? ctl_q.ovr : 16'h0;
    assign link_up   = ctl_q.link_up;
    assign fail      = ctl_q.fail;
endmodule

// File: rtl/lt_supervisor_chk.sv
module lt_supervisor_chk #(
    parameter logic [15:0] OVR_ADDR = 16'h1005
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        link_up,
    input logic        fail,
    input logic        train_en,
    input logic        cap_we,
    input logic        phy_req,
    input logic        phy_we,
    input logic [15:0] phy_addr,
    input logic [15:0] phy_wdata,
    input logic        phy_ack
);
    AST_CAP_BEFORE_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en) |-> $past(cap_we)); // R2
    AST_UP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !start) |=> link_up); // R3
    AST_UP_NO_PHY: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> !phy_req); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))); // R4
    AST_WR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_we) |-> (phy_addr == OVR_ADDR)); // R6
    AST_FAIL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail); // R9
    AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!train_en && !link_up && !phy_req)); // R9
endmodule

bind lt_supervisor lt_supervisor_chk #(.OVR_ADDR(OVR_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .link_up   (link_up),
    .fail      (fail),
    .train_en  (train_en),
    .cap_we    (cap_we),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack)
);

// File: tb/sim_lt_supervisor.sv
`timescale 1ns/1ps
module sim_lt_supervisor;
    localparam int TD = 2;
    localparam int PT = 3;
    localparam int HT = 10;
    localparam int MP = 6;
    localparam logic [15:0] OVR_INIT = 16'h1241;
    localparam logic [31:0] CAP_VAL  = 32'hA5C3_E7FB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] link_stat = '0;
    logic [31:0] train_state = '0;
    logic [31:0] cap_rdata = CAP_VAL;
    logic        cap_we, train_en, phy_req, phy_we, link_up, fail;
    logic [31:0] cap_wdata;
    logic [15:0] phy_addr, phy_wdata;
    logic        phy_ack;
    logic [15:0] phy_rdata;
    logic [15:0] rx_reg = 16'h0001;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lt_supervisor #(
        .TICK_DIV(TD), .POLL_TICKS(PT), .HOLD_TICKS(HT), .MAX_POLLS(MP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .link_stat(link_stat), .train_state(train_state), .cap_rdata(cap_rdata),
        .cap_we(cap_we), .cap_wdata(cap_wdata), .train_en(train_en),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .link_up(link_up), .fail(fail)
    );

    // PHY model and access log
    logic [15:0] ovr_reg;
    int lat, cyc;
    int rx_reads, rx_gap, rx_last;
    int ovr_acc, ovr_writes;
    int wr_val [0:7];
    int wr_cyc [0:7];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            phy_ack <= 1'b0; phy_rdata <= '0; ovr_reg <= OVR_INIT; lat <= 0;
            rx_reads <= 0; rx_gap <= 0; rx_last <= 0; ovr_acc <= 0; ovr_writes <= 0;
        end else begin
            phy_ack <= 1'b0;
            if (phy_req && !phy_ack) begin
                if (lat == 2) begin
                    phy_ack <= 1'b1;
                    lat <= 0;
                    if (phy_addr != 16'h100D) ovr_acc <= ovr_acc + 1;
                    if (phy_we) begin
                        ovr_reg <= phy_wdata;
                        wr_val[ovr_writes % 8] <= int'(phy_wdata);
                        wr_cyc[ovr_writes % 8] <= cyc;
                        ovr_writes <= ovr_writes + 1;
                    end else if (phy_addr == 16'h100D) begin
                        phy_rdata <= rx_reg;
                        rx_reads <= rx_reads + 1;
                        rx_gap <= cyc - rx_last;
                        rx_last <= cyc;
                    end else begin
                        phy_rdata <= ovr_reg;
                    end
                end else begin
                    lat <= lat + 1;
                end
            end else begin
                lat <= 0;
            end
        end
    end

    initial cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(cap_we == 1'b1, "R2", "cap_we pulse", cap_we, 1);
        chk(cap_wdata == {CAP_VAL[31:4], 4'h1}, "R2", "cap_wdata", cap_wdata, {CAP_VAL[31:4], 4'h1});
        chk(train_en == 1'b0, "R2", "train_en during cap", train_en, 0);
        @(negedge clk);
        chk(cap_we == 1'b0, "R2", "cap_we width", cap_we, 0);
        chk(train_en == 1'b1, "R2", "train_en rise", train_en, 1);
    endtask

    task automatic wait_rx(input int target);
        for (int i = 0; i < 400 && rx_reads < target; i++) @(negedge clk);
    endtask

    task automatic wait_wr(input int target);
        for (int i = 0; i < 400 && ovr_writes < target; i++) @(negedge clk);
    endtask

    task automatic wait_up();
        for (int i = 0; i < 200 && !link_up; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!link_up && !fail && !train_en && !cap_we && !phy_req, "R1", "reset outputs",
            {link_up, fail, train_en, cap_we, phy_req}, 0);
    endtask

    task automatic t_quick_up();
        int rx0;
        rx0 = rx_reads;
        link_stat = 32'h0000_0010;
        do_start();
        @(negedge clk);
        chk(link_up == 1'b1, "R3", "link_up after first poll", link_up, 1);
        repeat (10) @(negedge clk);
        chk(link_up == 1'b1, "R3", "link_up held", link_up, 1);
        chk(rx_reads == rx0, "R3", "no phy read when up", rx_reads - rx0, 0);
    endtask

    task automatic t_training_flag();
        int rx0, w0;
        rx0 = rx_reads; w0 = ovr_acc;
        link_stat = 32'h2000_0010;
        rx_reg = 16'h0001;
        train_state = 32'h0000_000D;
        do_start();
        chk(link_up == 1'b0, "R3", "link_up cleared by start", link_up, 0);
        wait_rx(rx0 + 3);
        chk(rx_reads >= rx0 + 3, "R4", "status reads while training", rx_reads - rx0, 3);
        chk(rx_gap >= PT * TD, "R8", "poll spacing", rx_gap, PT * TD);
        chk(link_up == 1'b0, "R3", "training bit blocks up", link_up, 0);
        chk(ovr_acc == w0, "R5", "rx valid blocks recovery", ovr_acc - w0, 0);
        link_stat = 32'h0000_0010;
        wait_up();
        chk(link_up == 1'b1, "R3", "up after training clears", link_up, 1);
    endtask

    task automatic t_stuck();
        int w0;
        w0 = ovr_writes;
        link_stat = 32'h0;
        train_state = 32'h0000_000D;
        rx_reg = 16'h0000;
        do_start();
        wait_wr(w0 + 2);
        chk(ovr_writes == w0 + 2, "R6", "two override writes", ovr_writes - w0, 2);
        chk(wr_val[w0 % 8] == 32'h1269, "R6", "set write value", wr_val[w0 % 8], 32'h1269);
        chk(wr_val[(w0 + 1) % 8] == 32'h1241, "R6", "clear write value", wr_val[(w0 + 1) % 8], 32'h1241);
        chk(wr_cyc[(w0 + 1) % 8] - wr_cyc[w0 % 8] >= HT * TD, "R7", "hold min",
            wr_cyc[(w0 + 1) % 8] - wr_cyc[w0 % 8], HT * TD);
        chk(wr_cyc[(w0 + 1) % 8] - wr_cyc[w0 % 8] <= HT * TD + 20, "R7", "hold max",
            wr_cyc[(w0 + 1) % 8] - wr_cyc[w0 % 8], HT * TD + 20);
        link_stat = 32'h0000_0010;
        wait_up();
        chk(link_up == 1'b1, "R3", "up after recovery", link_up, 1);
    endtask

    task automatic t_code_mask();
        int rx0, a0, w0;
        link_stat = 32'h0;
        rx_reg = 16'h0000;
        train_state = 32'h0000_000C;
        rx0 = rx_reads; a0 = ovr_acc;
        do_start();
        wait_rx(rx0 + 3);
        chk(ovr_acc == a0, "R5", "other code no recovery", ovr_acc - a0, 0);
        w0 = ovr_writes;
        train_state = 32'hFFFF_FFCD;
        wait_wr(w0 + 2);
        chk(ovr_writes == w0 + 2, "R5", "upper code bits ignored", ovr_writes - w0, 2);
        link_stat = 32'h0000_0010;
        wait_up();
        chk(link_up == 1'b1, "R3", "up after masked recovery", link_up, 1);
    endtask

    task automatic t_coincide();
        int rx0, a0;
        link_stat = 32'h0000_0010;
        train_state = 32'h0000_000D;
        rx_reg = 16'h0000;
        rx0 = rx_reads; a0 = ovr_acc;
        do_start();
        @(negedge clk);
        chk(link_up == 1'b1, "R10", "up wins over stall", link_up, 1);
        repeat (5) @(negedge clk);
        chk(rx_reads == rx0 && ovr_acc == a0, "R10", "no phy access",
            (rx_reads - rx0) + (ovr_acc - a0), 0);
    endtask

    task automatic t_timeout();
        int rx0, n;
        link_stat = 32'h0;
        rx_reg = 16'h0001;
        rx0 = rx_reads;
        do_start();
        for (int i = 0; i < 600 && !fail; i++) @(negedge clk);
        chk(fail == 1'b1, "R9", "fail raised", fail, 1);
        chk(rx_reads - rx0 == MP, "R9", "polls before fail", rx_reads - rx0, MP);
        chk(train_en == 1'b0, "R9", "train_en dropped", train_en, 0);
        @(negedge clk);
        chk(fail == 1'b0, "R9", "fail width", fail, 0);
        n = rx_reads;
        repeat (30) @(negedge clk);
        chk(rx_reads == n && !phy_req && !link_up, "R9", "terminal quiet", rx_reads - n, 0);
    endtask

    task automatic t_last_wait();
        int rx0;
        link_stat = 32'h0;
        rx_reg = 16'h0001;
        rx0 = rx_reads;
        do_start();
        wait_rx(rx0 + MP);
        link_stat = 32'h0000_0010;
        for (int i = 0; i < 100 && !fail; i++) @(negedge clk);
        chk(fail == 1'b1, "R11", "fail despite late link", fail, 1);
        chk(link_up == 1'b0, "R11", "no up after budget", link_up, 0);
        do_start();
        @(negedge clk);
        chk(link_up == 1'b1, "R9", "restart after fail", link_up, 1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_quick_up();
        t_training_flag();
        t_stuck();
        t_code_mask();
        t_coincide();
        t_timeout();
        t_last_wait();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule